// File: doc/BRIEF.md
# Sub-band Requantizer with Statistics

This block takes a stream of filtered sub-band samples and reduces their precision for the correlator that follows. The samples are either real (one component) or complex (two components). Each component is multiplied by an unsigned gain with a fixed number of fractional bits and rounded to the nearest integer. The result is clipped symmetrically to either a 4-bit or a 7-bit signed range, picked at run time. A per-sample interference flag forces a sample out of the data path. The output word is still delivered, but its value is zero.

Next to the data path the block gathers statistics over a programmable number of samples:

- one occupancy count for every output code, kept for each component;
- the zero-lag power, which is the sum of the squared output codes;
- a count of the blanked samples.

At the end of each interval these are frozen in holding registers and a one-cycle done pulse is raised. The accumulators restart on the very next sample.

Control software sets the gain, the width mode and the interval length through a simple write port. It reads the held statistics through a combinational read port and closes its gain loop from them. New settings wait for the next interval boundary, so one interval is always processed with a single gain, width and length.

Top module: `sbq_requant_top`

## Requirements
- R1: For every input sample, out_valid is high on the next cycle. Each 7-bit output code is sat(floor((x*S + 2^(F-1)) / 2^F)). Here x is the signed input component, S is the active unsigned scale and F is SCALE_FRAC (8 by default). Ties round toward positive infinity.
- R2: The saturation is symmetric. In wide mode (mode value 1) the limits are +63 and -63. In narrow mode (mode value 0) the limits are +7 and -7, sign-extended into the 7-bit field. The code -64 never appears.
- R3: A sample whose in_blank flag is set is delivered with out_valid high and all output lanes zero. It adds nothing to the histogram or to the power sum, and it increments the blanked-sample count (read address 1).
- R4: The histogram counts, per lane, how often each code occurs in an interval. The held count for lane l and code c is read at address 0x100 + l*0x80 + (c mod 128). Lane 0 is the low IN_W bits of in_data, and lane 1 is the next IN_W bits.
- R5: The held zero-lag power, read at address 0, is the sum over the interval of the squares of all lane codes of the non-blanked samples.
- R6: The interval length L counts valid samples, whether blanked or not. The statistics of every L consecutive valid samples are copied to the holding registers, and stat_done is high for exactly one cycle. That cycle is the one after the last sample's output cycle. In back-to-back intervals no sample is lost or counted twice.
- R7: Writes to address 2 (scale), 3 (mode, bit 0) and 4 (interval length) are held as pending values. They become active at the next interval boundary, or on the next idle cycle if the current interval holds no sample yet. Reads of addresses 2, 3 and 4 return the active values.
- R8: After reset the block is in the following state:
  - out_valid and stat_done are low;
  - the held power, blanked count and histogram read zero;
  - the active scale is 2^SCALE_FRAC, which is a gain of one;
  - the mode is wide;
  - the interval length is DEF_INTV.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_blank | input | 1 | Interference flag for this sample |
| in_data | input | LANES*IN_W | Signed components, lane 0 in the low bits |
| out_valid | output | 1 | Output sample present |
| out_data | output | LANES*7 | Requantized signed codes, lane 0 in the low bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 9 | Configuration write address |
| cfg_wdata | input | CFG_W | Configuration write data |
| rd_addr | input | 9 | Statistics and settings read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| stat_done | output | 1 | One-cycle pulse when the held statistics are refreshed |

## Verification
The bench builds the block with its defaults:

- complex input with two lanes;
- 12-bit components;
- a 12-bit scale with 8 fractional bits;
- 16-bit interval counters.

These values keep every output code of both widths within reach of a linear input sweep, and all 256 histogram bins are read back after each sweep. A gain of one drives one lane through every wide code and into the clip on both sides. A gain of 0.375 in narrow mode hits the round-half-up ties on both signs, and a periodic blank flag is applied during that sweep. A short interval run back to back, with a gain write landing mid-interval, shows the boundary rule and the loss-free restart.

// File: rtl/sbq_pkg.sv
package sbq_pkg;
   localparam int WIDE_W   = 7;
   localparam int NARROW_W = 4;
   localparam int RD_W     = 32;

   typedef enum logic {
      QM_NARROW = 1'b0,
      QM_WIDE   = 1'b1
   } qmode_e;

   // register offsets (low part of the address space)
   localparam int REG_PWR   = 0;
   localparam int REG_BLANK = 1;
   localparam int REG_SCALE = 2;
   localparam int REG_MODE  = 3;
   localparam int REG_INTV  = 4;
endpackage

// File: rtl/sbq_lane_quant.sv
module sbq_lane_quant
   import sbq_pkg::*;
#(
   parameter int IN_W       = 12,
   parameter int SCALE_W    = 12,
   parameter int SCALE_FRAC = 8
) (
   input  logic signed [IN_W-1:0]   smp,
   input  logic        [SCALE_W-1:0] scale,
   input  qmode_e                    mode,
   output logic signed [WIDE_W-1:0]  code
);
   localparam int PROD_W = IN_W + SCALE_W + 1;
   localparam int RND    = (SCALE_FRAC > 0) ? (1 << (SCALE_FRAC - 1)) : 0;
   localparam logic signed [PROD_W-1:0] LIM_W = PROD_W'((1 << (WIDE_W - 1)) - 1);
   localparam logic signed [PROD_W-1:0] LIM_N = PROD_W'((1 << (NARROW_W - 1)) - 1);

   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] biased;
   logic signed [PROD_W-1:0] shifted;
   logic signed [PROD_W-1:0] lim;

   always_comb begin
      prod    = PROD_W'(smp) * $signed({1'b0, scale});
      biased  = prod + PROD_W'(RND);
      shifted = biased >>> SCALE_FRAC;
      lim     = (mode == QM_WIDE) ? LIM_W : LIM_N;
      if (shifted > lim)
         code = lim[WIDE_W-1:0];
      else if (shifted < -lim)
         code = -lim[WIDE_W-1:0];
      else
         code = shifted[WIDE_W-1:0];
   end
endmodule

// File: rtl/sbq_interval_ctl.sv
module sbq_interval_ctl
   import sbq_pkg::*;
#(
   parameter int SCALE_W    = 12,
   parameter int SCALE_FRAC = 8,
   parameter int INTV_W     = 16,
   parameter int DEF_INTV   = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               wr_scale,
   input  logic               wr_mode,
   input  logic               wr_intv,
   input  logic [SCALE_W-1:0] wr_scale_val,
   input  logic               wr_mode_val,
   input  logic [INTV_W-1:0]  wr_intv_val,
   output logic [SCALE_W-1:0] act_scale,
   output qmode_e             act_mode,
   output logic [INTV_W-1:0]  act_intv,
   output logic [INTV_W-1:0]  cnt_q,
   output logic               is_last
);
   localparam logic [SCALE_W-1:0] UNITY = SCALE_W'(1) << SCALE_FRAC;

   logic [SCALE_W-1:0] pend_scale;
   qmode_e             pend_mode;
   logic [INTV_W-1:0]  pend_intv;
   logic [INTV_W-1:0]  last_idx;
   logic               load;

   assign last_idx = (act_intv == '0) ? '0 : act_intv - 1'b1;
   assign is_last  = in_valid && (cnt_q == last_idx);
   assign load     = is_last || ((cnt_q == '0) && !in_valid);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_scale <= UNITY;
         pend_mode  <= QM_WIDE;
         pend_intv  <= INTV_W'(DEF_INTV);
      end else begin
         if (wr_scale) pend_scale <= wr_scale_val;
         if (wr_mode)  pend_mode  <= qmode_e'(wr_mode_val);
         if (wr_intv)  pend_intv  <= wr_intv_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_scale <= UNITY;
         act_mode  <= QM_WIDE;
         act_intv  <= INTV_W'(DEF_INTV);
         cnt_q     <= '0;
      end else begin
         if (load) begin
            act_scale <= pend_scale;
            act_mode  <= pend_mode;
            act_intv  <= pend_intv;
         end
         if (in_valid)
            cnt_q <= is_last ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sbq_stats.sv
module sbq_stats
   import sbq_pkg::*;
#(
   parameter int LANES = 2,
   parameter int CNT_W = 16,
   parameter int PWR_W = 29
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    s1_valid,
   input  logic                    s1_blank,
   input  logic                    s1_last,
   input  logic [LANES*WIDE_W-1:0] s1_codes,
   input  logic                    rd_lane,
   input  logic [WIDE_W-1:0]       rd_bin,
   output logic [CNT_W-1:0]        hist_rd,
   output logic [PWR_W-1:0]        pwr_hold,
   output logic [CNT_W-1:0]        blank_hold,
   output logic                    done
);
   localparam int NBIN = 1 << WIDE_W;

   logic             take;
   logic             close;
   logic [PWR_W-1:0] pwr_inc;
   logic [PWR_W-1:0] pwr_acc;
   logic [CNT_W-1:0] blank_acc;
   logic [CNT_W-1:0] lane_rd [LANES];

   assign take  = s1_valid && !s1_blank;
   assign close = s1_valid && s1_last;

   always_comb begin
      pwr_inc = '0;
      for (int l = 0; l < LANES; l++) begin
         logic signed [WIDE_W-1:0]   c;
         logic signed [2*WIDE_W-1:0] sq;
         c  = s1_codes[l*WIDE_W +: WIDE_W];
         sq = c * c;
         pwr_inc = pwr_inc + PWR_W'($unsigned(sq));
      end
      if (!take) pwr_inc = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_acc    <= '0;
         pwr_hold   <= '0;
         blank_acc  <= '0;
         blank_hold <= '0;
         done       <= 1'b0;
      end else begin
         done <= close;
         if (close) begin
            pwr_hold   <= pwr_acc + pwr_inc;
            blank_hold <= blank_acc + CNT_W'(s1_blank);
            pwr_acc    <= '0;
            blank_acc  <= '0;
         end else if (s1_valid) begin
            pwr_acc   <= pwr_acc + pwr_inc;
            blank_acc <= blank_acc + CNT_W'(s1_blank);
         end
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [CNT_W-1:0]  acc  [NBIN];
      logic [CNT_W-1:0]  hold [NBIN];
      logic [WIDE_W-1:0] bin;

      assign bin = s1_codes[l*WIDE_W +: WIDE_W];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int b = 0; b < NBIN; b++) begin
               acc[b]  <= '0;
               hold[b] <= '0;
            end
         end else begin
            for (int b = 0; b < NBIN; b++) begin
               if (close) begin
                  hold[b] <= acc[b] + CNT_W'(take && (bin == WIDE_W'(b)));
                  acc[b]  <= '0;
               end else if (take && (bin == WIDE_W'(b))) begin
                  acc[b] <= acc[b] + 1'b1;
               end
            end
         end
      end

      assign lane_rd[l] = hold[rd_bin];
   end

   if (LANES == 2) begin : g_rd2
      assign hist_rd = rd_lane ? lane_rd[1] : lane_rd[0];
   end else begin : g_rd1
      assign hist_rd = rd_lane ? '0 : lane_rd[0];
   end
endmodule

// File: rtl/sbq_requant_top.sv
module sbq_requant_top
   import sbq_pkg::*;
#(
   parameter int IN_W       = 12,
   parameter int SCALE_W    = 12,
   parameter int SCALE_FRAC = 8,
   parameter int INTV_W     = 16,
   parameter int DEF_INTV   = 256,
   parameter bit COMPLEX    = 1'b1,
   localparam int LANES     = COMPLEX ? 2 : 1,
   localparam int ADDR_W    = WIDE_W + 2,
   localparam int CFG_W     = (SCALE_W > INTV_W) ? SCALE_W : INTV_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_blank,
   input  logic [LANES*IN_W-1:0]   in_data,
   output logic                    out_valid,
   output logic [LANES*WIDE_W-1:0] out_data,
   input  logic                    cfg_we,
   input  logic [ADDR_W-1:0]       cfg_addr,
   input  logic [CFG_W-1:0]        cfg_wdata,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [RD_W-1:0]         rd_data,
   output logic                    stat_done
);
   localparam int PWR_W = INTV_W + 2 * (WIDE_W - 1) + $clog2(LANES);

   if (IN_W < 2) begin : g_err_in
      $error("IN_W must be at least 2");
   end
   if (SCALE_FRAC >= SCALE_W) begin : g_err_frac
      $error("SCALE_FRAC must be below SCALE_W so a gain of one fits");
   end
   if (PWR_W > RD_W) begin : g_err_pwr
      $error("INTV_W too large for the power read width");
   end
   if (DEF_INTV < 1 || DEF_INTV >= (1 << INTV_W)) begin : g_err_def
      $error("DEF_INTV out of range for INTV_W");
   end

   logic                    wr_scale, wr_mode, wr_intv;
   logic [SCALE_W-1:0]      act_scale;
   qmode_e                  act_mode;
   logic [INTV_W-1:0]       act_intv;
   logic [INTV_W-1:0]       cnt_q;
   logic                    is_last;
   logic [LANES*WIDE_W-1:0] codes;
   logic                    s1_blank, s1_last;
   logic [INTV_W-1:0]       hist_rd;
   logic [PWR_W-1:0]        pwr_hold;
   logic [INTV_W-1:0]       blank_hold;

   assign wr_scale = cfg_we && (cfg_addr == ADDR_W'(REG_SCALE));
   assign wr_mode  = cfg_we && (cfg_addr == ADDR_W'(REG_MODE));
   assign wr_intv  = cfg_we && (cfg_addr == ADDR_W'(REG_INTV));

   sbq_interval_ctl #(
      .SCALE_W(SCALE_W), .SCALE_FRAC(SCALE_FRAC),
      .INTV_W(INTV_W), .DEF_INTV(DEF_INTV)
   ) ctl_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .wr_scale(wr_scale), .wr_mode(wr_mode), .wr_intv(wr_intv),
      .wr_scale_val(SCALE_W'(cfg_wdata)), .wr_mode_val(cfg_wdata[0]),
      .wr_intv_val(INTV_W'(cfg_wdata)),
      .act_scale(act_scale), .act_mode(act_mode), .act_intv(act_intv),
      .cnt_q(cnt_q), .is_last(is_last)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_q
      sbq_lane_quant #(
         .IN_W(IN_W), .SCALE_W(SCALE_W), .SCALE_FRAC(SCALE_FRAC)
      ) q_i (
         .smp(in_data[l*IN_W +: IN_W]),
         .scale(act_scale),
         .mode(act_mode),
         .code(codes[l*WIDE_W +: WIDE_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         s1_blank  <= 1'b0;
         s1_last   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= in_blank ? '0 : codes;
            s1_blank <= in_blank;
            s1_last  <= is_last;
         end
      end
   end

   sbq_stats #(
      .LANES(LANES), .CNT_W(INTV_W), .PWR_W(PWR_W)
   ) st_i (
      .clk(clk), .rst_n(rst_n),
      .s1_valid(out_valid), .s1_blank(s1_blank), .s1_last(s1_last),
      .s1_codes(out_data),
      .rd_lane(rd_addr[WIDE_W]), .rd_bin(rd_addr[WIDE_W-1:0]),
      .hist_rd(hist_rd), .pwr_hold(pwr_hold), .blank_hold(blank_hold),
      .done(stat_done)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr[ADDR_W-1]) begin
         rd_data = RD_W'(hist_rd);
      end else begin
         case (rd_addr)
            ADDR_W'(REG_PWR):   rd_data = RD_W'(pwr_hold);
            ADDR_W'(REG_BLANK): rd_data = RD_W'(blank_hold);
            ADDR_W'(REG_SCALE): rd_data = RD_W'(act_scale);
            ADDR_W'(REG_MODE):  rd_data = RD_W'(act_mode);
            ADDR_W'(REG_INTV):  rd_data = RD_W'(act_intv);
            default:            rd_data = '0;
         endcase
      end
   end
endmodule

// File: rtl/sbq_requant_chk.sv
module sbq_requant_chk
   import sbq_pkg::*;
#(
   parameter int LANES   = 2,
   parameter int SCALE_W = 12,
   parameter int INTV_W  = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_blank,
   input logic                    out_valid,
   input logic [LANES*WIDE_W-1:0] out_data,
   input logic                    stat_done,
   input logic                    act_mode,
   input logic [SCALE_W-1:0]      act_scale,
   input logic [INTV_W-1:0]       cnt_q
);
   // R1
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R1
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R3
   blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_blank) |=> (out_data == '0));
   // R6
   done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_done |-> $past(out_valid));
   // R7
   scale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_scale) |-> (cnt_q == '0));

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic signed [WIDE_W-1:0] c;
      assign c = out_data[l*WIDE_W +: WIDE_W];
      // R2
      sym_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (c != {1'b1, {(WIDE_W-1){1'b0}}}));
      // R2
      narrow_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (act_mode == QM_NARROW)) |=> ((c <= 7) && (c >= -7)));
   end
endmodule

bind sbq_requant_top sbq_requant_chk #(
   .LANES(LANES), .SCALE_W(SCALE_W), .INTV_W(INTV_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_blank(in_blank),
   .out_valid(out_valid), .out_data(out_data), .stat_done(stat_done),
   .act_mode(act_mode), .act_scale(act_scale), .cnt_q(cnt_q)
);

// File: tb/sbq_requant_tb.sv
`timescale 1ns/1ps
module sbq_requant_top_tb_top;
   localparam int IN_W = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_blank = 1'b0;
   logic [23:0] in_data = '0;
   logic        out_valid;
   logic [13:0] out_data;
   logic        cfg_we = 1'b0;
   logic [8:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic [8:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        stat_done;

   int checks = 0;
   int errors = 0;
   int done_cnt = 0;

   int s_re [0:199];
   int s_im [0:199];
   bit s_bl [0:199];
   int s_sc [0:199];
   bit s_wd [0:199];
   int exp_hist [0:1][0:127];
   int exp_pwr;
   int exp_blank;

   always #4 clk = ~clk;

   sbq_requant_top dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_blank(in_blank),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .rd_addr(rd_addr), .rd_data(rd_data), .stat_done(stat_done)
   );

   always @(negedge clk) if (rst_n && stat_done) done_cnt++;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int qexp(input int x, input int s, input bit wide);
      int p, lim;
      p = (x * s + 128) >>> 8;
      lim = wide ? 63 : 7;
      if (p > lim) p = lim;
      if (p < -lim) p = -lim;
      return p;
   endfunction

   task automatic rd(input int a, output int v);
      rd_addr = 9'(a);
      #1;
      v = int'(rd_data);
   endtask

   task automatic cfg(input int a, input int d);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_addr = 9'(a);
      cfg_wdata = 16'(d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic clear_exp();
      for (int l = 0; l < 2; l++)
         for (int b = 0; b < 128; b++) exp_hist[l][b] = 0;
      exp_pwr = 0;
      exp_blank = 0;
   endtask

   // drives n samples back to back; a scale write lands with sample wr_at
   task automatic run_stream(input int n, input int len, input int wr_at, input int wr_val);
      for (int i = 0; i <= n; i++) begin
         @(negedge clk);
         if (i > 0) begin
            int j, e0, e1, a0, a1;
            j = i - 1;
            e0 = s_bl[j] ? 0 : qexp(s_re[j], s_sc[j], s_wd[j]);
            e1 = s_bl[j] ? 0 : qexp(s_im[j], s_sc[j], s_wd[j]);
            a0 = int'($signed(out_data[6:0]));
            a1 = int'($signed(out_data[13:7]));
            chk(out_valid && a0 == e0 && a1 == e1,
                s_bl[j] ? "R3 blanked output" : "R1 R2 requantized output",
                a0 * 1000 + a1, e0 * 1000 + e1);
            if (j >= n - len) begin
               if (s_bl[j]) exp_blank++;
               else begin
                  exp_hist[0][e0 & 127]++;
                  exp_hist[1][e1 & 127]++;
                  exp_pwr += e0 * e0 + e1 * e1;
               end
            end
         end
         cfg_we = 1'b0;
         if (i < n) begin
            in_valid = 1'b1;
            in_blank = s_bl[i];
            in_data = {12'(s_im[i]), 12'(s_re[i])};
            if (i == wr_at) begin
               cfg_we = 1'b1;
               cfg_addr = 9'd2;
               cfg_wdata = 16'(wr_val);
            end
         end else begin
            in_valid = 1'b0;
            in_blank = 1'b0;
         end
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic check_stats(input string tag);
      int v, lane_sum0, lane_sum1;
      rd(0, v); chk(v == exp_pwr, "R5 zero-lag power", v, exp_pwr);
      rd(1, v); chk(v == exp_blank, "R3 blanked count", v, exp_blank);
      lane_sum0 = 0;
      lane_sum1 = 0;
      for (int l = 0; l < 2; l++) begin
         for (int b = 0; b < 128; b++) begin
            rd(256 + l * 128 + b, v);
            if (l == 0) lane_sum0 += v; else lane_sum1 += v;
            chk(v == exp_hist[l][b], tag, v, exp_hist[l][b]);
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int v, dc0, hs0, hs1;
      repeat (3) @(negedge clk);
      // R8 reset state
      chk(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
      chk(stat_done == 1'b0, "R8 stat_done after reset", int'(stat_done), 0);
      rd(0, v); chk(v == 0, "R8 power after reset", v, 0);
      rd(2, v); chk(v == 256, "R8 scale after reset", v, 256);
      rd(3, v); chk(v == 1, "R8 mode after reset", v, 1);
      rd(4, v); chk(v == 256, "R8 interval after reset", v, 256);
      rd(256 + 5, v); chk(v == 0, "R8 histogram after reset", v, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // sweep A: wide mode, unity gain, every wide code plus clipping
      cfg(4, 161);
      repeat (2) @(negedge clk);
      rd(4, v); chk(v == 161, "R7 idle interval load", v, 161);
      for (int i = 0; i < 161; i++) begin
         s_re[i] = i - 80;
         s_im[i] = 3 * (i - 80);
         s_bl[i] = 1'b0;
         s_sc[i] = 256;
         s_wd[i] = 1'b1;
      end
      clear_exp();
      dc0 = done_cnt;
      run_stream(161, 161, -1, 0);
      chk(done_cnt == dc0 + 1, "R6 done pulses sweep A", done_cnt - dc0, 1);
      check_stats("R4 histogram sweep A");

      // sweep B: narrow mode, gain 0.375, periodic blanking
      cfg(2, 96);
      cfg(3, 0);
      cfg(4, 81);
      repeat (2) @(negedge clk);
      rd(2, v); chk(v == 96, "R7 scale readback", v, 96);
      rd(3, v); chk(v == 0, "R7 mode readback", v, 0);
      for (int i = 0; i < 81; i++) begin
         s_re[i] = i - 40;
         s_im[i] = 1 - 2 * (i - 40);
         s_bl[i] = (i % 7) == 3;
         s_sc[i] = 96;
         s_wd[i] = 1'b0;
      end
      clear_exp();
      dc0 = done_cnt;
      run_stream(81, 81, -1, 0);
      chk(done_cnt == dc0 + 1, "R6 done pulses sweep B", done_cnt - dc0, 1);
      check_stats("R4 R3 histogram sweep B");

      // run C: short back-to-back intervals, gain write mid-interval
      cfg(2, 256);
      cfg(3, 1);
      cfg(4, 10);
      repeat (2) @(negedge clk);
      for (int i = 0; i < 30; i++) begin
         s_re[i] = i - 15;
         s_im[i] = 20 - i;
         s_bl[i] = 1'b0;
         s_sc[i] = (i < 10) ? 256 : 512;
         s_wd[i] = 1'b1;
      end
      clear_exp();
      dc0 = done_cnt;
      run_stream(30, 10, 5, 512);
      chk(done_cnt == dc0 + 3, "R6 done pulses back to back", done_cnt - dc0, 3);
      rd(2, v); chk(v == 512, "R7 scale after boundary", v, 512);
      check_stats("R6 histogram last interval");
      hs0 = 0;
      hs1 = 0;
      for (int b = 0; b < 128; b++) begin
         rd(256 + b, v); hs0 += v;
         rd(384 + b, v); hs1 += v;
      end
      chk(hs0 == 10, "R6 lane0 samples per interval", hs0, 10);
      chk(hs1 == 10, "R6 lane1 samples per interval", hs1, 10);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule